// File: doc/BRIEF.md
# Serial Flash Generic Command Shifter

This block runs one single-lane SPI flash transaction of up to 56 bit-clocks, driven entirely from a small byte-wide register bank. Software fills six transmit byte registers, sets a length in bits and writes a start bit. The engine then lowers chip select and clocks the bits out on one data line, most significant bit first, in SPI mode 0. At the same time it shifts the returning bits into a ten-byte receive window. The start bit reads back as busy until the transaction has finished.

Transmit byte 5 goes out first and byte 0 goes out last. Once the 48 loaded bits have been sent, zeros follow. The receive window behaves as one long shift register: byte 0 always holds the most recent eight bits, byte 1 the eight bits before those, and so on. A typical use is a command byte, three address bytes and a few bytes of read data. Lengths above 56 are clamped to 56.

Top module: `sf_cmd_shifter`

## Requirements
- R1: After reset chip select is high, SCK and MOSI are low, the busy bit is 0, and every register reads 0.
- R2: The register map is: transmit byte i at address i (0 to 5), receive byte i at address 6+i (0 to 9), bit count at 16, and control at 17 with bit 0 as start/busy. Reads are combinational from the address.
- R3: Bit k of a transaction (k counted from 0) is bit 7-(k mod 8) of transmit byte 5-(k div 8) for k < 48, and 0 for k >= 48.
- R4: A transaction produces exactly min(count, 56) SCK rising edges. Counts above 56 are clamped to 56.
- R5: SCK is low while idle. MOSI changes only while SCK is low, and MISO is sampled on each rising SCK edge.
- R6: With H = HALF_DIV clock cycles, the first SCK rise comes H cycles after chip select falls, SCK rises are 2H cycles apart, and chip select rises H cycles after the last SCK fall.
- R7: A started transaction first clears the receive window. After N bits, bit j of the 80-bit window (byte i holds window bits 8i+7..8i) equals the bit received j positions before the last, and is 0 where j >= N.
- R8: Writing 1 to control bit 0 with a nonzero count makes busy read 1 from the next cycle. Busy clears on the same edge that chip select rises.
- R9: A start with count 0 completes at once: chip select never falls, busy never reads 1, and the receive window keeps its contents.
- R10: While busy, writes to the transmit bytes, the bit count and the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| sck_o | output | 1 | SPI serial clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The bench builds the block with HALF_DIV = 2, so a full 56-bit transaction takes roughly 230 clock cycles. This short length makes it practical to sweep every bit count from 0 to 60 in one run. The sweep covers the zero-length case, lengths that are not whole bytes, the step from loaded bits to zero fill at bit 48, the limit of 56 and the clamp above it. A behavioural slave supplies a MISO pattern that depends on the count, and the bench checks each receive window against an arithmetic model. The same slave measures the lead, period and trail times in units of H.

// File: rtl/sfcs_pkg.sv
`timescale 1ns/1ps
package sfcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } sfcs_state_e;
endpackage

// File: rtl/sfcs_clkdiv.sv
`timescale 1ns/1ps
module sfcs_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/sfcs_regbank.sv
`timescale 1ns/1ps
module sfcs_regbank #(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int ADDR_W   = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  input  logic                  busy_i,
  input  logic                  clr_rx_i,
  input  logic                  shift_i,
  input  logic                  shift_bit_i,
  output logic [8*TX_BYTES-1:0] tx_vec_o,
  output logic [7:0]            len_o,
  output logic                  start_o
);
  localparam int RX_BITS = 8 * RX_BYTES;
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(TX_BYTES + RX_BYTES);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(TX_BYTES + RX_BYTES + 1);

  logic [7:0]         tx_q [TX_BYTES];
  logic [RX_BITS-1:0] rx_q;
  logic [7:0]         len_q;
  logic               wr_ok;

  assign wr_ok   = wr_en_i && !busy_i;
  assign start_o = wr_ok && (addr_i == A_CTL) && wdata_i[0];
  assign len_o   = len_q;

  for (genvar i = 0; i < TX_BYTES; i++) begin : g_tx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tx_q[i] <= '0;
      else if (wr_ok && addr_i == ADDR_W'(i))     tx_q[i] <= wdata_i;
    end
    assign tx_vec_o[8*i +: 8] = tx_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        len_q <= '0;
    else if (wr_ok && addr_i == A_CNT)  len_q <= wdata_i;
  end

  // receive window: bit 0 is always the newest sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (clr_rx_i) rx_q <= '0;
    else if (shift_i)  rx_q <= {rx_q[RX_BITS-2:0], shift_bit_i};
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < TX_BYTES; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = tx_q[i];
    for (int i = 0; i < RX_BYTES; i++)
      if (addr_i == ADDR_W'(TX_BYTES + i)) rdata_o = rx_q[8*i +: 8];
    if (addr_i == A_CNT) rdata_o = len_q;
    if (addr_i == A_CTL) rdata_o = {7'b0, busy_i};
  end
endmodule

// File: rtl/sfcs_engine.sv
`timescale 1ns/1ps
module sfcs_engine
  import sfcs_pkg::*;
#(
  parameter int TX_BITS  = 48,
  parameter int MAX_BITS = 56
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         len_i,
  input  logic [TX_BITS-1:0] tx_vec_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic               busy_o,
  output logic               clr_rx_o,
  output logic               sample_o,
  output logic               sck_o,
  output logic               cs_no,
  output logic               mosi_o
);
  localparam int CW = $clog2(MAX_BITS + 1);

  sfcs_state_e   state_q;
  logic [CW-1:0] len_q, idx_q, len_eff;
  logic          sck_q, cs_nq, go;

  assign len_eff  = (int'(len_i) > MAX_BITS) ? CW'(MAX_BITS) : len_i[CW-1:0];
  assign go       = start_i && (len_i != '0);
  assign clr_rx_o = go && (state_q == ST_IDLE);
  assign run_o    = (state_q != ST_IDLE);
  assign busy_o   = run_o;
  assign sample_o = tick_i && !sck_q && (state_q == ST_LEAD || state_q == ST_SHIFT);
  assign sck_o    = sck_q;
  assign cs_no    = cs_nq;

  always_comb begin
    mosi_o = 1'b0;
    if (!cs_nq && int'(idx_q) < TX_BITS) mosi_o = tx_vec_i[TX_BITS - 1 - int'(idx_q)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
      sck_q   <= 1'b0;
      cs_nq   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_LEAD;
          len_q   <= len_eff;
          idx_q   <= '0;
          cs_nq   <= 1'b0;
        end
        ST_LEAD: if (tick_i) begin
          sck_q   <= 1'b1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          if (sck_q) begin
            sck_q <= 1'b0;
            if (idx_q == len_q - CW'(1)) state_q <= ST_TRAIL;
            else                         idx_q   <= idx_q + CW'(1);
          end else begin
            sck_q <= 1'b1;
          end
        end
        ST_TRAIL: if (tick_i) begin
          cs_nq   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sf_cmd_shifter.sv
`timescale 1ns/1ps
module sf_cmd_shifter #(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int TX_BITS = 8 * TX_BYTES;

  logic [TX_BITS-1:0] tx_vec;
  logic [7:0]         len;
  logic start, busy, run, tick, clr_rx, sample;

  sfcs_regbank #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_i(busy), .clr_rx_i(clr_rx),
    .shift_i(sample), .shift_bit_i(miso_i), .tx_vec_o(tx_vec), .len_o(len),
    .start_o(start)
  );

  sfcs_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  sfcs_engine #(.TX_BITS(TX_BITS), .MAX_BITS(MAX_BITS)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .len_i(len),
    .tx_vec_i(tx_vec), .tick_i(tick), .run_o(run), .busy_o(busy),
    .clr_rx_o(clr_rx), .sample_o(sample), .sck_o(sck_o), .cs_no(cs_no),
    .mosi_o(mosi_o)
  );
endmodule

// File: rtl/sfcs_chk.sv
`timescale 1ns/1ps
module sfcs_chk #(
  parameter int TX_BITS = 48
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sck_o,
  input logic               cs_no,
  input logic               mosi_o,
  input logic               busy,
  input logic               start,
  input logic [7:0]         len,
  input logic [TX_BITS-1:0] tx_vec
);
  // R5
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  // R5
  mosi_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));
  // R5
  mosi_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  // R8
  cs_implies_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy);
  // R9
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && len == 8'd0 && !busy) |=> (cs_no && !busy));
  // R10
  tx_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(tx_vec));
endmodule

bind sf_cmd_shifter sfcs_chk #(.TX_BITS(TX_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .cs_no(cs_no),
  .mosi_o(mosi_o), .busy(busy), .start(start), .len(len), .tx_vec(tx_vec)
);

// File: tb/sim_sf_cmd_shifter.sv
`timescale 1ns/1ps
module sim_sf_cmd_shifter;
  localparam int  HALF  = 2;
  localparam real TCLK  = 5.0;
  localparam int  A_CNT = 16;
  localparam int  A_CTL = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sck, cs_n, mosi, miso;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sf_cmd_shifter #(.HALF_DIV(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  // behavioural slave
  logic [63:0] pat = '0, cap = '0;
  int idx = 0, rises = 0, cs_falls = 0, per_bad = 0, mosi_bad = 0;
  realtime t_csf, t_csr, t_r1, t_rprev, t_flast;

  assign miso = (idx < 64) ? pat[idx] : 1'b0;

  always @(negedge cs_n) begin idx = 0; cs_falls++; t_csf = $realtime; end
  always @(posedge cs_n) t_csr = $realtime;
  always @(posedge sck) begin
    if (idx == 0) t_r1 = $realtime;
    else if ($realtime - t_rprev != 2 * HALF * TCLK) per_bad++;
    t_rprev = $realtime;
    if (idx < 64) cap[idx] = mosi;
    idx++;
    rises++;
  end
  always @(negedge sck) t_flast = $realtime;
  always @(mosi) if (sck) mosi_bad++;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 5'(a);
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(A_CTL, v);
      if (v[0] == 1'b0) return;
      @(negedge clk);
    end
    chk(1'b0, "R8 busy never cleared", 80'(v), 80'(0));
  endtask

  function automatic logic [63:0] exp_mosi(input logic [47:0] txv, input int n);
    logic [63:0] e = '0;
    for (int k = 0; k < n; k++) e[k] = (k < 48) ? txv[47-k] : 1'b0;
    return e;
  endfunction

  task automatic read_rx(output logic [79:0] v);
    logic [7:0] b;
    for (int i = 0; i < 10; i++) begin rd(6 + i, b); v[8*i +: 8] = b; end
  endtask

  logic [79:0] exp_rx = '0;

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 80'(0), 80'(1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [47:0] txv;
    logic [79:0] rxv;
    int eff, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R1 pins", 80'({cs_n, sck, mosi}), 80'(3'b100));
    begin
      int nz = 0;
      for (int a = 0; a < 18; a++) begin rd(a, v); if (v != 0) nz++; end
      chk(nz == 0, "R1 registers zero", 80'(nz), 80'(0));
    end

    // sweep every length including zero and the clamp region
    for (int n = 0; n <= 60; n++) begin
      eff = (n > 56) ? 56 : n;
      for (int i = 0; i < 6; i++) begin
        txv[8*i +: 8] = 8'(n * 37 + i * 91 + 5);
        wr(i, txv[8*i +: 8]);
      end
      wr(A_CNT, 8'(n));
      for (int k = 0; k < 64; k++) pat[k] = (((k * 7 + n * 3) % 5) < 2);
      cap = '0; rises = 0; per_bad = 0; f0 = cs_falls;
      wr(A_CTL, 8'h01);
      rd(A_CTL, v);
      chk(v[0] == (n != 0), $sformatf("R8 R9 busy after start n=%0d", n), 80'(v), 80'(n != 0));
      wait_idle();
      repeat (2) @(negedge clk);
      chk(rises == eff, $sformatf("R4 rise count n=%0d", n), 80'(rises), 80'(eff));
      chk(cap == exp_mosi(txv, eff), $sformatf("R3 mosi stream n=%0d", n), 80'(cap), 80'(exp_mosi(txv, eff)));
      if (eff > 0) begin
        for (int j = 0; j < 80; j++) exp_rx[j] = (j < eff) ? pat[eff-1-j] : 1'b0;
        chk(t_r1 - t_csf == HALF * TCLK, $sformatf("R6 lead n=%0d", n), 80'(int'(t_r1 - t_csf)), 80'(HALF * 5));
        chk(t_csr - t_flast == HALF * TCLK, $sformatf("R6 trail n=%0d", n), 80'(int'(t_csr - t_flast)), 80'(HALF * 5));
        chk(per_bad == 0, $sformatf("R6 period n=%0d", n), 80'(per_bad), 80'(0));
      end else begin
        chk(cs_falls == f0, "R9 no chip select on zero count", 80'(cs_falls - f0), 80'(0));
      end
      read_rx(rxv);
      chk(rxv == exp_rx, $sformatf("R2 R7 receive window n=%0d", n), rxv, exp_rx);
    end

    // R10 writes while busy are ignored
    for (int i = 0; i < 6; i++) begin txv[8*i +: 8] = 8'(i * 29 + 200); wr(i, txv[8*i +: 8]); end
    wr(A_CNT, 8'd16);
    cap = '0; rises = 0;
    wr(A_CTL, 8'h01);
    wr(0, 8'hFF);
    wr(A_CNT, 8'd3);
    wr(A_CTL, 8'h01);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rises == 16, "R10 length unchanged by busy writes", 80'(rises), 80'(16));
    chk(cap == exp_mosi(txv, 16), "R10 mosi unchanged by busy writes", 80'(cap), 80'(exp_mosi(txv, 16)));
    rd(0, v);
    chk(v == txv[7:0], "R10 tx byte 0 kept", 80'(v), 80'(txv[7:0]));
    rd(A_CNT, v);
    chk(v == 8'd16, "R10 count kept", 80'(v), 80'(16));
    rd(A_CTL, v);
    chk(v[0] == 1'b0, "R10 restart ignored", 80'(v), 80'(0));
    chk(mosi_bad == 0, "R5 mosi changed while sck high", 80'(mosi_bad), 80'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule